// File: doc/BRIEF.md
# Keyed Watchdog Enable Sequencer

This block turns a pair of 32-bit count and period registers into one 64-bit watchdog. Software first puts the timer into watchdog mode through a global control register. It then writes two fixed key values, in order, to the watchdog control register. This takes the block from `IDLE` through `PRE` (pre-active) to `LIVE` (active). In `LIVE` the 64-bit count grows by one every clock. The block drives a system reset pulse if the count reaches the 64-bit period, or if software writes the control register with a key the block does not know.

The four states are `IDLE`, `PRE`, `LIVE` and `FIRE`. The transitions are:
- **arm**: `IDLE` to `PRE`, on the first key with enable set, in watchdog mode.
- **go**: `PRE` to `LIVE`, on the second key with enable set.
- **abort**: `PRE` to `IDLE`, on any other control write.
- **bite**: `LIVE` to `FIRE`, on an unknown key.
- **expire**: `LIVE` to `FIRE`, when the count equals the period.
- **release**: `FIRE` to `IDLE`, after the pulse.

While in `LIVE`, writing the first key and then the second key clears the count. This is the service sequence.

Top module: `wdk_top`

## Requirements
- R1: After reset, the reset output is low, the enable bit reads 0, and the count, period and global registers read 0.
- R2: The registers are decoded at these byte offsets:
  - count low half at 0x10, count high half at 0x14;
  - period low half at 0x18, period high half at 0x1C;
  - global control at 0x24: bits [1:0] are the low/high half run bits, bits [3:2] are the mode field;
  - watchdog control at 0x28: bit 14 is enable, bits [31:16] are the key.

  Outside `LIVE`/`FIRE`, every register except watchdog control reads back what was written.
- R3: A control write with key 0xA5C6 and enable=1 moves `IDLE` to `PRE`, so enable reads 1. The write has no effect unless the mode field is 2 and both run bits are 1.
- R4: A control write with key 0xDA7E and enable=1 moves `PRE` to `LIVE`; the same write in `IDLE` has no effect. In `LIVE` the count increases by one per clock, starting in the cycle after the write.
- R5: In `PRE`, any control write other than key 0xDA7E with enable=1 returns the block to `IDLE` without a reset pulse.
- R6: In `LIVE`, a control write whose key is neither 0xA5C6 nor 0xDA7E asserts the reset output from the next cycle.
- R7: In `LIVE`, when the 64-bit count equals the 64-bit period, the reset output asserts in the next cycle. The count carries from the low half into the high half.
- R8: The reset pulse lasts exactly RST_CYC cycles. After it the block is in `IDLE` with the count at 0.
- R9: In `LIVE`, the enable bit cannot be cleared: a valid key with enable=0 leaves it at 1. Writes to the count, period and global registers are also ignored.
- R10: In `LIVE`, writing key 0xA5C6 and then key 0xDA7E clears the count on the second write, and counting resumes from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | HALF_W | Write data |
| rdata | output | HALF_W | Read data, combinational on addr |
| wd_rst_o | output | 1 | System reset pulse |

## Verification
Writes take effect at the clock edge that samples them. A state change is therefore visible at the falling edge that follows. The bench drives at a falling edge and checks at the next falling edges.

After the go write, the count reads k at the k-th falling edge. With period P and a start count of 0, the reset is expected high at falling edges P+1 through P+RST_CYC and low elsewhere. The bench sweeps P from 0 to 8 and compares every falling edge against this window.

A bad key in `LIVE` must show the reset at the first falling edge after the write. Ignored writes are checked by reading the register back straight after the write.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_PRE  = 2'd1,
        WD_LIVE = 2'd2,
        WD_FIRE = 2'd3
    } wd_state_e;

    // byte offsets of the register slots
    localparam int unsigned OFS_CNT_LO = 'h10;
    localparam int unsigned OFS_CNT_HI = 'h14;
    localparam int unsigned OFS_PRD_LO = 'h18;
    localparam int unsigned OFS_PRD_HI = 'h1C;
    localparam int unsigned OFS_GLOB   = 'h24;
    localparam int unsigned OFS_WDCTL  = 'h28;

    localparam int unsigned CTL_EN_BIT = 14;
    localparam int unsigned GLOB_W     = 4;
    localparam logic [1:0]  MODE_WDOG  = 2'd2;

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              lock,
    input  logic              inc,
    input  logic              clr,
    input  logic              en_flag,
    output logic              cnt_hit,
    output logic              mode_ok,
    output logic [HALF_W-1:0] rdata
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  prd_q;
    logic [GLOB_W-1:0] glob_q;
    logic              sw_wr;

    assign sw_wr   = wr_en && !lock;
    assign cnt_hit = (cnt_q == prd_q);
    assign mode_ok = (glob_q[3:2] == MODE_WDOG) && (glob_q[1:0] == 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (sw_wr && addr == ADDR_W'(OFS_CNT_LO)) begin
            cnt_q[HALF_W-1:0] <= wdata;
        end else if (sw_wr && addr == ADDR_W'(OFS_CNT_HI)) begin
            cnt_q[CNT_W-1:HALF_W] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_q  <= '0;
            glob_q <= '0;
        end else if (sw_wr) begin
            if (addr == ADDR_W'(OFS_PRD_LO)) prd_q[HALF_W-1:0]     <= wdata;
            if (addr == ADDR_W'(OFS_PRD_HI)) prd_q[CNT_W-1:HALF_W] <= wdata;
            if (addr == ADDR_W'(OFS_GLOB))   glob_q                <= wdata[GLOB_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CNT_LO)) rdata = cnt_q[HALF_W-1:0];
        if (addr == ADDR_W'(OFS_CNT_HI)) rdata = cnt_q[CNT_W-1:HALF_W];
        if (addr == ADDR_W'(OFS_PRD_LO)) rdata = prd_q[HALF_W-1:0];
        if (addr == ADDR_W'(OFS_PRD_HI)) rdata = prd_q[CNT_W-1:HALF_W];
        if (addr == ADDR_W'(OFS_GLOB))   rdata = HALF_W'(glob_q);
        if (addr == ADDR_W'(OFS_WDCTL))  rdata = HALF_W'(en_flag) << CTL_EN_BIT;
    end

endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
    import wdk_pkg::*;
#(
    parameter int unsigned KEY_W   = 16,
    parameter int unsigned RST_CYC = 4,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic [KEY_W-1:0] ctl_key,
    input  logic             mode_ok,
    input  logic             cnt_hit,
    output wd_state_e        st,
    output logic             inc,
    output logic             clr,
    output logic             lock,
    output logic             en_flag,
    output logic             wd_rst
);
    localparam int unsigned PC_W = $clog2(RST_CYC + 1);

    wd_state_e       st_nx;
    logic [PC_W-1:0] pcnt_q;
    logic            svc_pend_q;
    logic            key_arm, key_go, key_bad, pulse_end;

    assign key_arm   = (ctl_key == KEY_ARM);
    assign key_go    = (ctl_key == KEY_GO);
    assign key_bad   = !key_arm && !key_go;
    assign pulse_end = (pcnt_q == PC_W'(RST_CYC - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            WD_IDLE: if (ctl_wr && ctl_en && key_arm && mode_ok) st_nx = WD_PRE;
            WD_PRE:  if (ctl_wr) st_nx = (ctl_en && key_go) ? WD_LIVE : WD_IDLE;
            WD_LIVE: if ((ctl_wr && key_bad) || cnt_hit)         st_nx = WD_FIRE;
            WD_FIRE: if (pulse_end)                              st_nx = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q     <= '0;
            svc_pend_q <= 1'b0;
        end else begin
            pcnt_q <= (st == WD_FIRE) ? pcnt_q + 1'b1 : '0;
            if (st != WD_LIVE)            svc_pend_q <= 1'b0;
            else if (ctl_wr && key_arm)   svc_pend_q <= 1'b1;
            else if (ctl_wr && key_go)    svc_pend_q <= 1'b0;
        end
    end

    always_comb begin
        inc     = (st == WD_LIVE) && !cnt_hit;
        clr     = (st == WD_FIRE) ||
                  ((st == WD_LIVE) && ctl_wr && key_go && svc_pend_q);
        lock    = (st == WD_LIVE) || (st == WD_FIRE);
        en_flag = (st == WD_PRE) || (st == WD_LIVE);
        wd_rst  = (st == WD_FIRE);
    end

endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned KEY_W   = 16,
    parameter int unsigned RST_CYC = 4,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              wd_rst_o
);
    localparam int unsigned KEY_LSB = HALF_W - KEY_W;

    wd_state_e        st;
    logic             ctl_wr, ctl_en, mode_ok, cnt_hit;
    logic             inc, clr, lock, en_flag;
    logic [KEY_W-1:0] ctl_key;

    assign ctl_wr  = wr_en && (addr == ADDR_W'(OFS_WDCTL));
    assign ctl_en  = wdata[CTL_EN_BIT];
    assign ctl_key = wdata[KEY_LSB +: KEY_W];

    wdk_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lock(lock), .inc(inc), .clr(clr), .en_flag(en_flag),
        .cnt_hit(cnt_hit), .mode_ok(mode_ok), .rdata(rdata)
    );

    wdk_fsm #(.KEY_W(KEY_W), .RST_CYC(RST_CYC), .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_key(ctl_key),
        .mode_ok(mode_ok), .cnt_hit(cnt_hit), .st(st), .inc(inc), .clr(clr),
        .lock(lock), .en_flag(en_flag), .wd_rst(wd_rst_o)
    );

endmodule

// File: rtl/wdk_chk.sv
module wdk_chk
    import wdk_pkg::*;
#(
    parameter int unsigned KEY_W   = 16,
    parameter int unsigned RST_CYC = 4,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wd_rst_o,
    input wd_state_e        st,
    input logic             ctl_wr,
    input logic             ctl_en,
    input logic [KEY_W-1:0] ctl_key,
    input logic             cnt_hit
);
    logic [31:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_len <= '0;
        else if (wd_rst_o) hi_len <= hi_len + 1;
        else               hi_len <= '0;
    end

    AST_BAD_KEY_BITES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_LIVE && ctl_wr && ctl_key != KEY_ARM && ctl_key != KEY_GO) |=> wd_rst_o); // R6
    AST_EXPIRE_BITES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_LIVE && cnt_hit) |=> wd_rst_o); // R7
    AST_PRE_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_PRE && ctl_wr && !(ctl_en && ctl_key == KEY_GO)) |=> (st == WD_IDLE && !wd_rst_o)); // R5
    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |-> (hi_len < RST_CYC)); // R8
    AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_o) |-> (hi_len == RST_CYC)); // R8
    AST_NO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_LIVE) |=> (st == WD_LIVE || st == WD_FIRE)); // R9

endmodule

bind wdk_top wdk_chk #(.KEY_W(KEY_W), .RST_CYC(RST_CYC), .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)) u_chk (
    .clk(clk), .rst_n(rst_n), .wd_rst_o(wd_rst_o), .st(st), .ctl_wr(ctl_wr),
    .ctl_en(ctl_en), .ctl_key(ctl_key), .cnt_hit(cnt_hit)
);

// File: tb/tb_wdk_top.sv
module tb_wdk_top;
    localparam int HALF_W = 32;
    localparam int ADDR_W = 8;
    localparam int PULSE  = 4;
    localparam logic [31:0] C_ARM = 32'hA5C6_4000;
    localparam logic [31:0] C_GO  = 32'hDA7E_4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [HALF_W-1:0] wdata = '0;
    logic [HALF_W-1:0] rdata;
    logic              wd_rst_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    wdk_top #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .RST_CYC(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wd_rst_o(wd_rst_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic arm_go();
        wr(8'h28, C_ARM);
        wr(8'h28, C_GO);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rst out", {63'd0, wd_rst_o}, 0);
        rd(8'h28, v); chk("R1 enable", v, 0);
        rd(8'h10, v); chk("R1 count", v, 0);
        rd(8'h18, v); chk("R1 period", v, 0);
        rd(8'h24, v); chk("R1 global", v, 0);
        // R3 arm without watchdog mode is ignored
        wr(8'h28, C_ARM); rd(8'h28, v); chk("R3 no mode", v, 0);
        // R2 global and period readback
        wr(8'h24, 32'hB); rd(8'h24, v); chk("R2 global", v, 32'hB);
        wr(8'h1C, 32'h1234_5678); rd(8'h1C, v); chk("R2 prd hi", v, 32'h1234_5678);
        wr(8'h14, 32'h0000_00AB); rd(8'h14, v); chk("R2 cnt hi", v, 32'hAB);
        wr(8'h14, 0); wr(8'h1C, 0);
        // R3 enable bit clear blocks arming
        wr(8'h28, 32'hA5C6_0000); rd(8'h28, v); chk("R3 en=0", v, 0);
        // R4 go key in idle has no effect
        wr(8'h28, C_GO); rd(8'h28, v); chk("R4 go in idle", v, 0);
        // R3 arm, then R5 wrong key aborts quietly
        wr(8'h28, C_ARM); rd(8'h28, v); chk("R3 pre", v, 32'h4000);
        wr(8'h28, 32'h1234_4000); rd(8'h28, v); chk("R5 abort en", v, 0);
        chk("R5 abort rst", {63'd0, wd_rst_o}, 0);
        wr(8'h28, C_ARM); wr(8'h28, C_ARM); rd(8'h28, v); chk("R5 re-arm aborts", v, 0);

        // R4 R7 R8 sweep over small periods
        for (int p = 0; p <= 8; p++) begin
            wr(8'h10, 0); wr(8'h18, p);
            arm_go();
            rd(8'h28, v); chk("R4 live en", v, 32'h4000);
            for (int k = 1; k <= p + PULSE + 1; k++) begin
                @(negedge clk);
                if (k <= p) begin rd(8'h10, v); chk("R4 count step", v, k); end
                chk("R7 R8 rst window", {63'd0, wd_rst_o}, (k >= p + 1 && k <= p + PULSE) ? 1 : 0);
            end
            rd(8'h28, v); chk("R8 idle after", v, 0);
            rd(8'h10, v); chk("R8 count zero", v, 0);
        end

        // R7 carry from low into high half: distance 10
        wr(8'h10, 32'hFFFF_FFFA); wr(8'h14, 0); wr(8'h18, 4); wr(8'h1C, 1);
        arm_go();
        repeat (6) @(negedge clk);
        rd(8'h10, v); chk("R7 carry lo", v, 0);
        rd(8'h14, v); chk("R7 carry hi", v, 1);
        repeat (4) @(negedge clk);
        chk("R7 before hit", {63'd0, wd_rst_o}, 0);
        @(negedge clk);
        chk("R7 hit", {63'd0, wd_rst_o}, 1);
        repeat (PULSE) @(negedge clk);
        chk("R8 released", {63'd0, wd_rst_o}, 0);

        // R9 lock and enable held; R10 service; R6 bad key
        wr(8'h1C, 0); wr(8'h18, 100); wr(8'h10, 0); wr(8'h14, 0);
        arm_go();
        wr(8'h18, 5); rd(8'h18, v); chk("R9 period locked", v, 100);
        wr(8'h24, 0); rd(8'h24, v); chk("R9 global locked", v, 32'hB);
        wr(8'h28, 32'hDA7E_0000); rd(8'h28, v); chk("R9 enable held", v, 32'h4000);
        chk("R9 no rst", {63'd0, wd_rst_o}, 0);
        wr(8'h28, C_ARM); wr(8'h28, C_GO);
        rd(8'h10, v); chk("R10 cleared", v, 0);
        repeat (2) @(negedge clk);
        rd(8'h10, v); chk("R10 resumes", v, 2);
        wr(8'h28, 32'h0000_4000);
        chk("R6 bite", {63'd0, wd_rst_o}, 1);
        repeat (PULSE) @(negedge clk);
        chk("R6 pulse ends", {63'd0, wd_rst_o}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule